// File: doc/BRIEF.md
# Bidirectional Half-Word Shift Unit

This unit shifts one 16-bit half of a 32-bit source word by a signed amount and writes the result into either half of a 32-bit destination word. A single signed count gives both the distance and the direction: positive values move bits toward the most significant end, and negative values move them toward the least significant end. A mode input selects arithmetic shifting, where a right shift replicates the sign bit, or logical shifting, where a right shift brings in zeros.

The source half and the destination half are chosen independently. The half of the destination that is not written keeps the previous destination contents supplied with the operation. Every strobed operation returns the merged 32-bit word and five status flags one clock later, together with a one-cycle valid pulse. The unit sits beside a register file: the file supplies the source word, the count word and the old destination word, and it writes back the merged word.

Top module: `hws_shift_unit`

## Requirements
- R1: Only count bits [5:0] are used, read as a two's-complement value from -32 to +31. Count bits [31:6] have no effect, so a count word whose low six bits are 63 behaves as -1 (0x0100 gives 0x0080).
- R2: A count of zero returns the selected source half unchanged. A positive count c shifts it left by c places and fills with zeros (0x0001 by 4 gives 0x0010, 0x0001 by 15 gives 0x8000).
- R3: When in_logical is 0 (arithmetic), a negative count -m shifts right by m places and fills with copies of bit 15 (0x8000 by -4 gives 0xF800). At -32 the result is sixteen copies of bit 15.
- R4: When in_logical is 1 (logical), a negative count -m shifts right by m places and fills with zeros (0x8000 by -4 gives 0x0800). At -32 the result is 0x0000.
- R5: A left count of 16 to 31 gives 0x0000 in both modes (0xFFFF by 31 arithmetic, 0x0100 by 31 logical).
- R6: in_src_hi=1 takes source bits [31:16] and 0 takes bits [15:0]. in_dst_hi=1 puts the result in out_word[31:16] and 0 puts it in out_word[15:0]. All four pairings are allowed.
- R7: The destination half that is not written equals the matching half of in_dst_prev.
- R8: out_zero is 1 exactly when the 16-bit result is zero.
- R9: out_neg is 1 exactly when bit 15 of the 16-bit result is 1.
- R10: out_carry, out_ovf0 and out_ovf1 are 0 after every operation, including 0xFFFF shifted left by 31.
- R11: out_valid is high in the cycle after each cycle in which in_valid is high, and low otherwise. out_word and the flags are updated only by a strobe and otherwise hold their values. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_logical | input | 1 | 1 = logical, 0 = arithmetic |
| in_src_hi | input | 1 | Source half select |
| in_dst_hi | input | 1 | Destination half select |
| in_src | input | 32 | Source word |
| in_count | input | 32 | Count word (bits [5:0] used) |
| in_dst_prev | input | 32 | Old destination word |
| out_valid | output | 1 | Result valid pulse |
| out_word | output | 32 | Merged destination word |
| out_zero | output | 1 | Result is zero |
| out_neg | output | 1 | Result bit 15 set |
| out_carry | output | 1 | Carry flag |
| out_ovf0 | output | 1 | First overflow flag |
| out_ovf1 | output | 1 | Second overflow flag |

## Verification
Two things can happen in the same cycle: the unit presents the merged result of one operation while it captures the operands of the next. The bench provokes this with strobes on consecutive cycles that change mode, count sign and half selection every cycle, and it includes a full sweep of all 64 count values. A scoreboard queue holds the expected word and flags for each strobe in issue order. Each presented result is compared with the head of the queue, so a result that is lost, repeated or mixed with its neighbour shows up as a mismatch.

// File: rtl/hws_pkg.sv
package hws_pkg;
   typedef enum logic {
      HWS_ARITH = 1'b0,
      HWS_LOGIC = 1'b1
   } hws_mode_e;

   typedef struct packed {
      logic zero;
      logic neg;
      logic carry;
      logic ovf0;
      logic ovf1;
   } hws_flags_t;
endpackage

// File: rtl/hws_count_decode.sv
module hws_count_decode #(
   parameter int CNT_W = 6
) (
   input  logic [CNT_W-1:0] cnt,
   output logic             go_left,
   output logic [CNT_W-1:0] mag
);
   always_comb begin
      go_left = ~cnt[CNT_W-1];
      if (go_left) mag = cnt;
      else         mag = ~cnt + 1'b1;
   end
endmodule

// File: rtl/hws_barrel.sv
module hws_barrel #(
   parameter int W     = 16,
   parameter int CNT_W = 6
) (
   input  logic [W-1:0]     din,
   input  logic             go_left,
   input  logic             fill_bit,
   input  logic [CNT_W-1:0] mag,
   output logic [W-1:0]     dout
);
   logic [W-1:0] stg [0:CNT_W];
   assign stg[0] = din;

   for (genvar k = 0; k < CNT_W; k++) begin : g_stage
      localparam longint SH = longint'(1) << k;
      if (SH >= W) begin : g_flush
         assign stg[k+1] = mag[k] ? (go_left ? '0 : {W{fill_bit}}) : stg[k];
      end else begin : g_move
         localparam int S = int'(SH);
         logic [W-1:0] lft, rgt;
         assign lft = {stg[k][W-S-1:0], {S{1'b0}}};
         assign rgt = {{S{fill_bit}}, stg[k][W-1:S]};
         assign stg[k+1] = mag[k] ? (go_left ? lft : rgt) : stg[k];
      end
   end

   assign dout = stg[CNT_W];
endmodule

// File: rtl/hws_merge.sv
module hws_merge #(
   parameter int W = 16
) (
   input  logic [W-1:0]   res,
   input  logic           dst_hi,
   input  logic [2*W-1:0] prev,
   output logic [2*W-1:0] merged
);
   always_comb begin
      if (dst_hi) merged = {res, prev[W-1:0]};
      else        merged = {prev[2*W-1:W], res};
   end
endmodule

// File: rtl/hws_flag_gen.sv
module hws_flag_gen
   import hws_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] res,
   output hws_flags_t   flags
);
   always_comb begin
      flags.zero  = (res == '0);
      flags.neg   = res[W-1];
      flags.carry = 1'b0;
      flags.ovf0  = 1'b0;
      flags.ovf1  = 1'b0;
   end
endmodule

// File: rtl/hws_shift_unit.sv
module hws_shift_unit
   import hws_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int CNT_W  = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic                in_logical,
   input  logic                in_src_hi,
   input  logic                in_dst_hi,
   input  logic [2*HALF_W-1:0] in_src,
   input  logic [2*HALF_W-1:0] in_count,
   input  logic [2*HALF_W-1:0] in_dst_prev,
   output logic                out_valid,
   output logic [2*HALF_W-1:0] out_word,
   output logic                out_zero,
   output logic                out_neg,
   output logic                out_carry,
   output logic                out_ovf0,
   output logic                out_ovf1
);
   localparam int WORD_W = 2 * HALF_W;

   if (HALF_W < 2) begin : g_bad_half
      $error("hws_shift_unit: HALF_W must be at least 2");
   end
   if (CNT_W < 2 || CNT_W > WORD_W) begin : g_bad_cnt
      $error("hws_shift_unit: CNT_W out of range");
   end

   logic [HALF_W-1:0] src_half;
   logic [HALF_W-1:0] shifted;
   logic [CNT_W-1:0]  mag;
   logic              go_left;
   logic              fill_bit;
   logic [WORD_W-1:0] merged;
   hws_flags_t        flags_d;
   hws_mode_e         mode;

   assign mode     = hws_mode_e'(in_logical);
   assign src_half = in_src_hi ? in_src[WORD_W-1:HALF_W] : in_src[HALF_W-1:0];
   assign fill_bit = (mode == HWS_ARITH) ? src_half[HALF_W-1] : 1'b0;

   hws_count_decode #(.CNT_W(CNT_W)) u_dec (
      .cnt     (in_count[CNT_W-1:0]),
      .go_left (go_left),
      .mag     (mag)
   );

   hws_barrel #(.W(HALF_W), .CNT_W(CNT_W)) u_bar (
      .din      (src_half),
      .go_left  (go_left),
      .fill_bit (fill_bit),
      .mag      (mag),
      .dout     (shifted)
   );

   hws_merge #(.W(HALF_W)) u_mrg (
      .res    (shifted),
      .dst_hi (in_dst_hi),
      .prev   (in_dst_prev),
      .merged (merged)
   );

   hws_flag_gen #(.W(HALF_W)) u_flg (
      .res   (shifted),
      .flags (flags_d)
   );

   hws_flags_t flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
         flags_q   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word <= merged;
            flags_q  <= flags_d;
         end
      end
   end

   assign out_zero  = flags_q.zero;
   assign out_neg   = flags_q.neg;
   assign out_carry = flags_q.carry;
   assign out_ovf0  = flags_q.ovf0;
   assign out_ovf1  = flags_q.ovf1;
endmodule

// File: rtl/hws_shift_checks.sv
module hws_shift_checks #(
   parameter int HALF_W = 16,
   parameter int CNT_W  = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_logical,
   input logic                in_src_hi,
   input logic                in_dst_hi,
   input logic [2*HALF_W-1:0] in_src,
   input logic [2*HALF_W-1:0] in_count,
   input logic [2*HALF_W-1:0] in_dst_prev,
   input logic                out_valid,
   input logic [2*HALF_W-1:0] out_word,
   input logic                out_zero,
   input logic                out_neg,
   input logic                out_carry,
   input logic                out_ovf0,
   input logic                out_ovf1
);
   localparam int WORD_W = 2 * HALF_W;

   logic [HALF_W-1:0] out_hi, out_lo;
   assign out_hi = out_word[WORD_W-1:HALF_W];
   assign out_lo = out_word[HALF_W-1:0];

   a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_zero == (($past(in_dst_hi) ? out_hi : out_lo) == '0));

   a_r9_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_neg == ($past(in_dst_hi) ? out_hi[HALF_W-1] : out_lo[HALF_W-1]));

   a_r7_keep_other: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(in_dst_hi) ? (out_lo == $past(in_dst_prev[HALF_W-1:0]))
                                      : (out_hi == $past(in_dst_prev[WORD_W-1:HALF_W]))));

   a_r2_zero_count_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_count[CNT_W-1:0] == '0) |=>
         (($past(in_dst_hi) ? out_hi : out_lo) ==
          ($past(in_src_hi) ? $past(in_src[WORD_W-1:HALF_W]) : $past(in_src[HALF_W-1:0]))));

   a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> $stable(out_word));
endmodule

bind hws_shift_unit hws_shift_checks #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_hws_shift_unit.sv
module sim_hws_shift_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_logical = 1'b0, in_src_hi = 1'b0, in_dst_hi = 1'b0;
   logic [31:0] in_src = '0, in_count = '0, in_dst_prev = '0;
   logic        out_valid, out_zero, out_neg, out_carry, out_ovf0, out_ovf1;
   logic [31:0] out_word;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   hws_shift_unit u0 (.*);

   typedef struct {
      logic [31:0] word;
      logic        z;
      logic        n;
      string       tag;
   } exp_t;
   exp_t sb[$];

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] model(input logic [15:0] v, input logic [5:0] c6, input bit lg);
      int          c;
      int          m;
      logic [31:0] t;
      longint      sv;
      c = $signed(c6);
      if (c >= 0) begin
         t = {16'h0, v} << c;
         return t[15:0];
      end
      m = -c;
      if (lg) begin
         t = {16'h0, v} >> m;
         return t[15:0];
      end
      sv = longint'($signed(v));
      sv = sv >>> m;
      return sv[15:0];
   endfunction

   // Driver: issue one strobe at a falling edge and queue what it must produce
   task automatic issue(input logic [31:0] src, input logic [31:0] cnt, input bit lg,
                        input bit shi, input bit dhi, input logic [31:0] prev, input string tag);
      logic [15:0] h, r;
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1; in_logical = lg; in_src_hi = shi; in_dst_hi = dhi;
      in_src = src; in_count = cnt; in_dst_prev = prev;
      h = shi ? src[31:16] : src[15:0];
      r = model(h, cnt[5:0], lg);
      e.word = dhi ? {r, prev[15:0]} : {prev[31:16], r};
      e.z = (r == 16'h0);
      e.n = r[15];
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Monitor: compare each presented result with the head of the queue
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check(0, "R11 unexpected valid", 32'(out_valid), 32'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(out_word === e.word, e.tag, out_word, e.word);
            check(out_zero === e.z, "R8 zero flag", 32'(out_zero), 32'(e.z));
            check(out_neg === e.n, "R9 neg flag", 32'(out_neg), 32'(e.n));
            check({out_carry, out_ovf0, out_ovf1} === 3'b000, "R10 carry/ovf",
                  32'({out_carry, out_ovf0, out_ovf1}), 32'h0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         check(0, "watchdog", 32'h0, 32'h1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0 && out_word == 32'h0 && {out_zero, out_neg, out_carry, out_ovf0, out_ovf1} == 5'b0,
            "R11 reset state", out_word, 32'h0);
      rst_n = 1'b1;

      // directed cases, back to back
      issue(32'h0001_0001, 32'd4,          0, 0, 0, 32'hAAAA_5555, "R2 left arith");
      issue(32'h0001_8000, 32'h0000_FFFC,  0, 0, 0, 32'h1234_0000, "R3 arith right -4");
      issue(32'h0001_0000, 32'd0,          0, 0, 0, 32'h0, "R2 zero count");
      issue(32'h8000_0001, 32'h0000_FFFC,  0, 1, 1, 32'hCAFE_BEEF, "R6 R7 hi to hi");
      issue(32'h8000_0001, 32'h0000_FFFC,  0, 1, 0, 32'hCAFE_BEEF, "R6 hi to lo");
      issue(32'hFFFF_0001, 32'd31,         0, 1, 0, 32'h0, "R5 arith left 31");
      issue(32'h0100_0001, 32'hABCD_FFFF,  0, 1, 0, 32'h0, "R1 count 63 arith");
      issue(32'h8000_0001, 32'h0000_FFFC,  1, 1, 0, 32'h0, "R4 logic right -4");
      issue(32'h0001_0001, 32'd4,          1, 0, 1, 32'h0000_7777, "R6 lo to hi");
      issue(32'h0000_0001, 32'd15,         1, 0, 0, 32'h0, "R2 logic left 15");
      issue(32'h0000_0100, 32'h0000_003F,  1, 0, 0, 32'h0, "R1 count 63 logic");
      issue(32'h0000_0100, 32'd31,         1, 0, 0, 32'h0, "R5 logic left 31");
      issue(32'h0000_8001, 32'h0000_0020,  0, 0, 0, 32'h0, "R3 arith -32");
      issue(32'h0000_8001, 32'h0000_0020,  1, 0, 0, 32'h0, "R4 logic -32");
      issue(32'h0000_7FFF, 32'h0000_0020,  0, 0, 0, 32'h0, "R3 arith -32 positive");
      issue(32'h0000_1234, 32'hFFFF_FFC0,  1, 0, 1, 32'h5A5A_5A5A, "R1 upper count bits");
      idle();
      @(negedge clk);
      held = out_word;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && out_word == held, "R11 hold when idle", out_word, held);

      // sweep every count in both modes, alternating halves
      for (int c = 0; c < 64; c++) begin
         issue(32'hB6D3_49C5, 32'(c), c[0], c[1], c[2], 32'h0F0F_F0F0, "R3 R4 sweep");
         issue(32'h4C21_8E7F, 32'(c) | 32'h0400_0000, ~c[0], ~c[1], c[2], 32'h1357_9BDF, "R1 R2 sweep");
      end
      idle();
      repeat (4) @(negedge clk);
      check(sb.size() == 0, "R11 all results seen", 32'(sb.size()), 32'h0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule